// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block is one channel of a direct memory access engine. Software sets it up through a small indexed register port. The setup covers a source start address, a destination start address, a total unit count, an area count, a configuration word, an address offset, a control word and an interrupt-enable word. Once the channel is enabled, it waits for a trigger. The trigger is either a software start bit or a level request from a peripheral. For each trigger it moves data over a simple request/acknowledge memory port: one read from the current source address, then one write of that data to the current destination address.

After each unit the source and destination addresses are updated independently. Each side can stay fixed, add the offset register, step up or step down by the unit size. In repeat mode one side is a wrapping area that returns to its start address every area-count units. Block mode uses the same wrap, but one trigger moves a whole area's worth of units. When the total count runs out, the channel disables itself and raises a completion flag. A trigger that arrives while the configuration holds a forbidden code raises an abort flag instead and moves nothing. Each flag drives the interrupt output when its enable bit is set.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset every register reads 0, the memory request output is low and the interrupt output is low.
- R2: Register indices are: 0 source start, 1 destination start, 2 total count (26 bits), 3 area count (16 bits), 4 configuration, 5 offset, 6 control (bit0 enable, bit1 software start, bit2 keep-start), 7 status (bit0 active, read-only; bit1 done flag; bit2 abort flag), 8 interrupt enables (bit0 done, bit1 abort). With enable at 0 no trigger is honoured. With enable at 1, each unit is a read of the source address followed by a write of the returned data to the destination address. A rising write of enable copies the start addresses and both counts into the working state.
- R3: Configuration bits [1:0] select the mode: 00 normal, 01 repeat, 10 block. Bits [3:2] select the area side: 00 destination, 01 source, 10 none. Bits [5:4] select the unit size: 00 byte, 01 halfword, 10 word. The size is also driven on the memory size output. The code 11 in any of these three fields is forbidden. A trigger that meets a forbidden code moves nothing, clears enable and sets the abort flag.
- R4: Configuration bits [9:8] (source) and [11:10] (destination) choose the address update: 00 fixed, 01 add the offset register, 10 increment by the unit size in bytes, 11 decrement by the unit size in bytes.
- R5: With keep-start at 0, the software start bit clears when a unit begins, so each write of the bit starts exactly one trigger. With keep-start at 1, the bit stays set and units keep running back to back.
- R6: Configuration bits [7:6] select the trigger: 00 the software start bit, 01 the peripheral request input. When 01 is selected the software start bit starts nothing.
- R7: When the unit that empties the total count completes, enable clears, the done flag sets and the active bit reads 0. Exactly the programmed number of units is moved.
- R8: In repeat mode, after every area-count units the area-side address reloads its start value, while the other side keeps advancing.
- R9: In block mode one trigger moves area-count units back to back (fewer if the total runs out first), and the area-side address reloads after each block.
- R10: Writing 0 to a flag bit clears it and writing 1 leaves it unchanged. The interrupt output is high while a flag is set together with its enable bit.
- R11: An area count of 0 stands for 65,536 units, so a short repeat transfer with area count 0 never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regIdx | input | 4 | Register index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| periphReq | input | 1 | Peripheral transfer request level |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write access, 0 = read access |
| memAddr | output | 32 | Memory address |
| memSize | output | 2 | Unit size code |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memAck on a read |
| memAck | input | 1 | Access completes at the clock edge where it is high |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the area wrap, the block chain and the count boundary. If the repeat area reloaded on the wrong side or one unit late, the write addresses would drift away from the two-entry cycle the scoreboard expects. If the block chain broke after one unit, the second and third units of a peripheral-triggered block would never show up. If the end test were off by one, an extra or missing bus access would appear before the done flag.

Several triggers are aimed at inputs that must have no effect. A start bit written while enable is 0, a start bit written while the peripheral trigger is selected, and a forbidden mode or size code must each leave the bus silent. In the forbidden-code case the abort flag must also set. An area count of 0 must not wrap inside a three-unit repeat run. The keep-start bit is checked both ways through the control readback.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int REG_IDX_W = 4;

  localparam logic [REG_IDX_W-1:0] RI_SRC    = 4'd0;
  localparam logic [REG_IDX_W-1:0] RI_DST    = 4'd1;
  localparam logic [REG_IDX_W-1:0] RI_TOTAL  = 4'd2;
  localparam logic [REG_IDX_W-1:0] RI_AREA   = 4'd3;
  localparam logic [REG_IDX_W-1:0] RI_CFG    = 4'd4;
  localparam logic [REG_IDX_W-1:0] RI_OFS    = 4'd5;
  localparam logic [REG_IDX_W-1:0] RI_CTRL   = 4'd6;
  localparam logic [REG_IDX_W-1:0] RI_STATUS = 4'd7;
  localparam logic [REG_IDX_W-1:0] RI_IRQEN  = 4'd8;

  localparam int CFG_W = 12;

  typedef enum logic [1:0] {XM_NORMAL = 2'b00, XM_REPEAT = 2'b01, XM_BLOCK = 2'b10, XM_BAD = 2'b11} xferMode_e;
  typedef enum logic [1:0] {AS_DST = 2'b00, AS_SRC = 2'b01, AS_NONE = 2'b10, AS_BAD = 2'b11} areaSel_e;
  typedef enum logic [1:0] {AU_FIXED = 2'b00, AU_OFFSET = 2'b01, AU_INC = 2'b10, AU_DEC = 2'b11} addrUpd_e;
  typedef enum logic [1:0] {S_IDLE = 2'b00, S_RD = 2'b01, S_WR = 2'b10} seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic step;
    logic setEnd;
    logic setEsc;
    logic clrEnable;
    logic clrSw;
  } ctrlStrobe_t;

  // channel state seen by control
  typedef struct packed {
    logic enable;
    logic swStart;
    logic keepStart;
    logic usePeriph;
    logic cfgBad;
    logic isBlock;
    logic totLast;
    logic areaLast;
  } chanStat_t;

endpackage

// File: rtl/dma_seq_addr.sv
module dma_seq_addr
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] offset,
  input  addrUpd_e          upd,
  input  logic [2:0]        stepBytes,
  input  logic              reload,
  output logic [ADDR_W-1:0] nxtAddr
);

  logic [ADDR_W-1:0] stepExt;
  assign stepExt = ADDR_W'(stepBytes);

  always_comb begin
    if (reload) begin
      nxtAddr = startAddr;
    end else begin
      unique case (upd)
        AU_FIXED:  nxtAddr = curAddr;
        AU_OFFSET: nxtAddr = curAddr + offset;
        AU_INC:    nxtAddr = curAddr + stepExt;
        default:   nxtAddr = curAddr - stepExt;
      endcase
    end
  end

endmodule

// File: rtl/dma_seq_dpath.sv
module dma_seq_dpath
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TOT_W  = 26,
  parameter int AREA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [REG_IDX_W-1:0] regIdx,
  input  logic [ADDR_W-1:0]    regWdata,
  output logic [ADDR_W-1:0]    regRdata,
  input  ctrlStrobe_t          strb,
  input  logic                 busy,
  input  logic [DATA_W-1:0]    memRdata,
  output chanStat_t            stat,
  output logic [ADDR_W-1:0]    srcAddr,
  output logic [ADDR_W-1:0]    dstAddr,
  output logic [DATA_W-1:0]    dataBuf,
  output logic [1:0]           sizeCode,
  output logic                 irq
);

  localparam int NSIDE = 2; // 0 = source, 1 = destination

  logic [ADDR_W-1:0] srcStart, dstStart, offset;
  logic [TOT_W-1:0]  totCount, remTot;
  logic [AREA_W-1:0] areaCount, remArea;
  logic [CFG_W-1:0]  cfgWord;
  logic enable, swStart, keepStart, endFlag, escFlag, endIe, escIe;

  xferMode_e mode;
  areaSel_e  areaSel;
  logic [1:0] reqSrc;
  logic [2:0] stepBytes;
  logic load, areaWrap;

  assign mode     = xferMode_e'(cfgWord[1:0]);
  assign areaSel  = areaSel_e'(cfgWord[3:2]);
  assign sizeCode = cfgWord[5:4];
  assign reqSrc   = cfgWord[7:6];
  assign stepBytes = (sizeCode == 2'b00) ? 3'd1 : (sizeCode == 2'b01) ? 3'd2 : 3'd4;

  assign load     = regWe && (regIdx == RI_CTRL) && regWdata[0] && !enable;
  assign areaWrap = strb.step && (mode != XM_NORMAL) && stat.areaLast;

  assign stat.enable    = enable;
  assign stat.swStart   = swStart;
  assign stat.keepStart = keepStart;
  assign stat.usePeriph = (reqSrc == 2'b01);
  assign stat.cfgBad    = (mode == XM_BAD) || (areaSel == AS_BAD) || (sizeCode == 2'b11) || reqSrc[1];
  assign stat.isBlock   = (mode == XM_BLOCK);
  assign stat.totLast   = (remTot == TOT_W'(1));
  assign stat.areaLast  = (remArea == AREA_W'(1));

  // per-side address update
  logic [ADDR_W-1:0] curAddr [NSIDE];
  logic [ADDR_W-1:0] startAddr [NSIDE];
  logic [ADDR_W-1:0] nxtAddr [NSIDE];
  addrUpd_e          updSel [NSIDE];
  logic [NSIDE-1:0]  reloadSide;

  assign startAddr[0] = srcStart;
  assign startAddr[1] = dstStart;
  assign updSel[0]    = addrUpd_e'(cfgWord[9:8]);
  assign updSel[1]    = addrUpd_e'(cfgWord[11:10]);
  assign reloadSide[0] = areaWrap && (areaSel == AS_SRC);
  assign reloadSide[1] = areaWrap && (areaSel == AS_DST);

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dma_seq_addr #(.ADDR_W(ADDR_W)) u_addr (
      .curAddr  (curAddr[s]),
      .startAddr(startAddr[s]),
      .offset   (offset),
      .upd      (updSel[s]),
      .stepBytes(stepBytes),
      .reload   (reloadSide[s]),
      .nxtAddr  (nxtAddr[s])
    );
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           curAddr[s] <= '0;
      else if (load)       curAddr[s] <= startAddr[s];
      else if (strb.step)  curAddr[s] <= nxtAddr[s];
    end
  end

  assign srcAddr = curAddr[0];
  assign dstAddr = curAddr[1];

  // configuration and flags; hardware strobes take priority over software
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcStart <= '0; dstStart <= '0; offset <= '0;
      totCount <= '0; areaCount <= '0; cfgWord <= '0;
      enable <= 1'b0; swStart <= 1'b0; keepStart <= 1'b0;
      endFlag <= 1'b0; escFlag <= 1'b0; endIe <= 1'b0; escIe <= 1'b0;
    end else begin
      if (regWe) begin
        unique case (regIdx)
          RI_SRC:   srcStart  <= regWdata;
          RI_DST:   dstStart  <= regWdata;
          RI_TOTAL: totCount  <= regWdata[TOT_W-1:0];
          RI_AREA:  areaCount <= regWdata[AREA_W-1:0];
          RI_CFG:   cfgWord   <= regWdata[CFG_W-1:0];
          RI_OFS:   offset    <= regWdata;
          RI_CTRL: begin
            enable    <= regWdata[0];
            swStart   <= regWdata[1];
            keepStart <= regWdata[2];
          end
          RI_STATUS: begin
            if (!regWdata[1]) endFlag <= 1'b0;
            if (!regWdata[2]) escFlag <= 1'b0;
          end
          RI_IRQEN: begin
            endIe <= regWdata[0];
            escIe <= regWdata[1];
          end
          default: ;
        endcase
      end
      if (strb.clrSw)     swStart <= 1'b0;
      if (strb.clrEnable) enable  <= 1'b0;
      if (strb.setEnd)    endFlag <= 1'b1;
      if (strb.setEsc)    escFlag <= 1'b1;
    end
  end

  // working counts and data holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remTot  <= '0;
      remArea <= '0;
      dataBuf <= '0;
    end else begin
      if (strb.capture) dataBuf <= memRdata;
      if (load) begin
        remTot  <= totCount;
        remArea <= areaCount;
      end else if (strb.step) begin
        remTot <= remTot - TOT_W'(1);
        if (mode != XM_NORMAL) remArea <= stat.areaLast ? areaCount : remArea - AREA_W'(1);
      end
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regIdx)
      RI_SRC:    regRdata = srcStart;
      RI_DST:    regRdata = dstStart;
      RI_TOTAL:  regRdata[TOT_W-1:0] = totCount;
      RI_AREA:   regRdata[AREA_W-1:0] = areaCount;
      RI_CFG:    regRdata[CFG_W-1:0] = cfgWord;
      RI_OFS:    regRdata = offset;
      RI_CTRL:   regRdata[2:0] = {keepStart, swStart, enable};
      RI_STATUS: regRdata[2:0] = {escFlag, endFlag, busy};
      RI_IRQEN:  regRdata[1:0] = {escIe, endIe};
      default:   regRdata = '0;
    endcase
  end

  assign irq = (endFlag && endIe) || (escFlag && escIe);

  p_end_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.setEnd |=> (endFlag && !enable));

  p_dst_reload_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && reloadSide[1]) |=> (curAddr[1] == $past(dstStart)));

  p_src_reload_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && reloadSide[0]) |=> (curAddr[0] == $past(srcStart)));

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  chanStat_t   stat,
  input  logic        periphReq,
  input  logic        memAck,
  output logic        memReq,
  output logic        memWe,
  output logic        busy,
  output ctrlStrobe_t strb
);

  seqState_e state, nextState;
  logic pending;

  assign pending = stat.usePeriph ? periphReq : stat.swStart;
  assign busy    = (state != S_IDLE);

  always_comb begin
    nextState = state;
    strb      = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (stat.enable && pending) begin
          if (stat.cfgBad) begin
            strb.setEsc    = 1'b1;
            strb.clrEnable = 1'b1;
          end else begin
            nextState  = S_RD;
            strb.clrSw = !stat.usePeriph && !stat.keepStart;
          end
        end
      end
      S_RD: begin
        memReq = 1'b1;
        if (memAck) begin
          strb.capture = 1'b1;
          nextState    = S_WR;
        end
      end
      S_WR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          strb.step = 1'b1;
          if (stat.totLast) begin
            strb.setEnd    = 1'b1;
            strb.clrEnable = 1'b1;
            nextState      = S_IDLE;
          end else if (stat.isBlock && !stat.areaLast) begin
            nextState = S_RD;
          end else begin
            nextState = S_IDLE;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  p_hold_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe)));

  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !stat.enable) |=> !memReq);

  p_abort_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.setEsc |=> !memReq);

  p_block_chain_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memAck && stat.isBlock && !stat.areaLast && !stat.totLast) |=> (memReq && !memWe));

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TOT_W  = 26,
  parameter int AREA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [REG_IDX_W-1:0] regIdx,
  input  logic [ADDR_W-1:0]    regWdata,
  output logic [ADDR_W-1:0]    regRdata,
  input  logic                 periphReq,
  output logic                 memReq,
  output logic                 memWe,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [1:0]           memSize,
  output logic [DATA_W-1:0]    memWdata,
  input  logic [DATA_W-1:0]    memRdata,
  input  logic                 memAck,
  output logic                 irq
);

  ctrlStrobe_t strb;
  chanStat_t   stat;
  logic busy;
  logic [ADDR_W-1:0] srcAddr, dstAddr;

  dma_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stat     (stat),
    .periphReq(periphReq),
    .memAck   (memAck),
    .memReq   (memReq),
    .memWe    (memWe),
    .busy     (busy),
    .strb     (strb)
  );

  dma_seq_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOT_W(TOT_W), .AREA_W(AREA_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .regWe   (regWe),
    .regIdx  (regIdx),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .strb    (strb),
    .busy    (busy),
    .memRdata(memRdata),
    .stat    (stat),
    .srcAddr (srcAddr),
    .dstAddr (dstAddr),
    .dataBuf (memWdata),
    .sizeCode(memSize),
    .irq     (irq)
  );

  assign memAddr = memWe ? dstAddr : srcAddr;

endmodule

// File: tb/dma_chan_seq_bench.sv
`timescale 1ns/1ps
module dma_chan_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regIdx = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        periphReq = 1'b0;
  logic        memReq, memWe, irq;
  logic [31:0] memAddr, memWdata;
  logic [1:0]  memSize;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;

  always #4 clk = ~clk;

  dma_chan_seq u_dma_chan_seq (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx), .regWdata(regWdata),
    .regRdata(regRdata), .periphReq(periphReq), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memSize(memSize), .memWdata(memWdata), .memRdata(memRdata),
    .memAck(memAck), .irq(irq)
  );

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
    logic [1:0]  size;
    string       tag;
  } busOp_t;

  busOp_t expQ[$];
  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic expectUnit(input string tag, input logic [31:0] src, input logic [31:0] dst, input logic [1:0] sz);
    expQ.push_back('{1'b0, src, pat(src), sz, tag});
    expQ.push_back('{1'b1, dst, pat(src), sz, tag});
  endtask

  // memory responder and monitor
  always @(negedge clk) begin
    if (rstN && memReq && !memAck) begin
      memAck = 1'b1;
      if (!memWe) memRdata = pat(memAddr);
      if (expQ.size() == 0) begin
        nChk++; nBad++;
        $display("FAIL R2 unexpected bus op act=we%0d addr %h exp=none", memWe, memAddr);
      end else begin
        busOp_t e;
        e = expQ.pop_front();
        chk({e.tag, " bus direction"}, {31'b0, memWe}, {31'b0, e.we});
        chk({e.tag, " bus address"}, memAddr, e.addr);
        chk({e.tag, " R3 bus size"}, {30'b0, memSize}, {30'b0, e.size});
        if (memWe) chk({e.tag, " write data"}, memWdata, e.data);
      end
    end else begin
      memAck = 1'b0;
    end
  end

  task automatic regWrite(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regIdx = idx; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] idx, output logic [31:0] d);
    @(negedge clk);
    regIdx = idx;
    #1;
    d = regRdata;
  endtask

  task automatic drain(input string tag);
    int t = 0;
    while (expQ.size() != 0 && t < 5000) begin
      @(posedge clk);
      t++;
    end
    repeat (10) @(posedge clk);
    chk({tag, " ops outstanding"}, expQ.size(), 0);
  endtask

  task automatic setup(input logic [31:0] src, input logic [31:0] dst, input logic [31:0] tot,
                       input logic [31:0] area, input logic [31:0] cfg, input logic [31:0] ofs);
    regWrite(4'd0, src);
    regWrite(4'd1, dst);
    regWrite(4'd2, tot);
    regWrite(4'd3, area);
    regWrite(4'd4, cfg);
    regWrite(4'd5, ofs);
    regWrite(4'd7, 32'h0);
  endtask

  function automatic logic [31:0] mkCfg(input int md, input int as, input int sz, input int rq,
                                        input int su, input int du);
    return 32'((du << 10) | (su << 8) | (rq << 6) | (sz << 4) | (as << 2) | md);
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int i = 0; i < 9; i++) begin
      regRead(4'(i), v);
      chk("R1 register reset", v, 32'h0);
    end
    chk("R1 memReq reset", {31'b0, memReq}, 32'h0);
    chk("R1 irq reset", {31'b0, irq}, 32'h0);

    // R2: start bit while disabled does nothing
    setup(32'h100, 32'h200, 32'd3, 32'd0, mkCfg(0, 2, 2, 0, 2, 2), 32'h0);
    regWrite(4'd6, 32'h2);
    repeat (20) @(posedge clk);
    regRead(4'd6, v);
    chk("R2 start held while disabled", v, 32'h2);

    // R2 R5 R7: normal mode, word, increment, self-clearing start
    expectUnit("R2 normal unit", 32'h100, 32'h200, 2'd2);
    regWrite(4'd6, 32'h3);
    drain("R2");
    regRead(4'd6, v);
    chk("R5 start bit self-cleared", v, 32'h1);
    regRead(4'd7, v);
    chk("R7 not done after 1 of 3", v, 32'h0);
    expectUnit("R4 increment word", 32'h104, 32'h204, 2'd2);
    regWrite(4'd6, 32'h3);
    drain("R4");
    expectUnit("R7 last unit", 32'h108, 32'h208, 2'd2);
    regWrite(4'd6, 32'h3);
    drain("R7");
    regRead(4'd7, v);
    chk("R7 done flag set, active low", v, 32'h2);
    regRead(4'd6, v);
    chk("R7 enable cleared", v & 32'h1, 32'h0);

    // R10: flag clearing and interrupt gating
    chk("R10 irq masked", {31'b0, irq}, 32'h0);
    regWrite(4'd8, 32'h1);
    #1 chk("R10 irq raised by done flag", {31'b0, irq}, 32'h1);
    regWrite(4'd7, 32'h6);
    regRead(4'd7, v);
    chk("R10 writing 1 keeps flag", v, 32'h2);
    regWrite(4'd7, 32'h0);
    regRead(4'd7, v);
    chk("R10 writing 0 clears flag", v, 32'h0);
    chk("R10 irq dropped", {31'b0, irq}, 32'h0);
    regWrite(4'd8, 32'h0);

    // R4 R5: fixed source, decrementing halfword destination, kept start bit
    setup(32'h300, 32'h400, 32'd2, 32'd0, mkCfg(0, 2, 1, 0, 0, 3), 32'h0);
    expectUnit("R4 fixed/decrement", 32'h300, 32'h400, 2'd1);
    expectUnit("R4 fixed/decrement", 32'h300, 32'h3FE, 2'd1);
    regWrite(4'd6, 32'h7);
    drain("R5 kept start");
    regRead(4'd6, v);
    chk("R5 start bit kept", v, 32'h6);

    // R4: offset addition on source, byte increment on destination
    setup(32'h500, 32'h600, 32'd2, 32'd0, mkCfg(0, 2, 0, 0, 1, 2), 32'h10);
    expectUnit("R4 offset/byte", 32'h500, 32'h600, 2'd0);
    expectUnit("R4 offset/byte", 32'h510, 32'h601, 2'd0);
    regWrite(4'd6, 32'h7);
    drain("R4 offset");

    // R8: repeat mode, destination area of 2
    setup(32'h1000, 32'h2000, 32'd5, 32'd2, mkCfg(1, 0, 2, 0, 2, 2), 32'h0);
    expectUnit("R8 repeat", 32'h1000, 32'h2000, 2'd2);
    expectUnit("R8 repeat", 32'h1004, 32'h2004, 2'd2);
    expectUnit("R8 repeat wrap", 32'h1008, 32'h2000, 2'd2);
    expectUnit("R8 repeat", 32'h100C, 32'h2004, 2'd2);
    expectUnit("R8 repeat wrap", 32'h1010, 32'h2000, 2'd2);
    regWrite(4'd6, 32'h7);
    drain("R8");
    regRead(4'd7, v);
    chk("R8 done after 5", v, 32'h2);

    // R9 R6: block mode, source area of 3, peripheral trigger
    setup(32'h10, 32'h20, 32'd6, 32'd3, mkCfg(2, 1, 0, 1, 2, 2), 32'h0);
    regWrite(4'd6, 32'h1);
    for (int k = 0; k < 3; k++) expectUnit("R9 block one", 32'h10 + 32'(k), 32'h20 + 32'(k), 2'd0);
    @(negedge clk); periphReq = 1'b1;
    @(negedge clk); periphReq = 1'b0;
    drain("R9 first block");
    regRead(4'd6, v);
    chk("R9 still enabled between blocks", v, 32'h1);
    regWrite(4'd6, 32'h3);
    repeat (20) @(posedge clk);
    regRead(4'd6, v);
    chk("R6 start bit ignored with peripheral trigger", v, 32'h3);
    for (int k = 0; k < 3; k++) expectUnit("R9 block two", 32'h10 + 32'(k), 32'h23 + 32'(k), 2'd0);
    @(negedge clk); periphReq = 1'b1;
    @(negedge clk); periphReq = 1'b0;
    drain("R9 second block");
    regRead(4'd7, v);
    chk("R9 done after two blocks", v, 32'h2);

    // R3: forbidden mode and forbidden size
    setup(32'h700, 32'h800, 32'd4, 32'd0, mkCfg(3, 2, 2, 0, 2, 2), 32'h0);
    regWrite(4'd8, 32'h2);
    regWrite(4'd6, 32'h3);
    repeat (20) @(posedge clk);
    regRead(4'd7, v);
    chk("R3 abort flag on forbidden mode", v, 32'h4);
    regRead(4'd6, v);
    chk("R3 enable cleared on abort", v & 32'h1, 32'h0);
    chk("R10 irq from abort flag", {31'b0, irq}, 32'h1);
    setup(32'h700, 32'h800, 32'd4, 32'd0, mkCfg(0, 2, 3, 0, 2, 2), 32'h0);
    regWrite(4'd6, 32'h3);
    repeat (20) @(posedge clk);
    regRead(4'd7, v);
    chk("R3 abort flag on forbidden size", v, 32'h4);
    regWrite(4'd8, 32'h0);

    // R11: area count 0 means no wrap in a short repeat run
    setup(32'h30, 32'h40, 32'd3, 32'd0, mkCfg(1, 0, 2, 0, 2, 2), 32'h0);
    expectUnit("R11 no wrap", 32'h30, 32'h40, 2'd2);
    expectUnit("R11 no wrap", 32'h34, 32'h44, 2'd2);
    expectUnit("R11 no wrap", 32'h38, 32'h48, 2'd2);
    regWrite(4'd6, 32'h7);
    drain("R11");
    regRead(4'd7, v);
    chk("R11 done", v, 32'h2);

    summary();
  end

endmodule